// File: doc/BRIEF.md
# System Control Port Register

A byte-wide, I/O-mapped control register for a PC-style platform. Software writes one byte at a single port address. Bit 1 of the stored byte drives the address-line-20 gate enable. Bit 0 asks for a system reset, but only when it changes from 0 to 1. A read at the port address returns the stored byte unchanged.

The block decodes the port address from strobe-qualified bus cycles. Reads and writes are single-cycle strobes, and read data is registered.

The reset request is a synchronous, active-high pulse. Its length is set by a parameter. The system reset sequencer samples this pulse.

There are two reset inputs:
- An asynchronous power-on reset clears the whole byte.
- A synchronous device reset clears only bit 0. The gate bit and the upper bits keep their values.

Top module: `sys_ctl_port`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the stored byte is 0x00, and `a20_en_o`, `sys_rst_req_o` and `rdata_o` are all 0.
- R2: A write is accepted only when `wr_i` is high, `addr_i` equals `PORT_ADDR` (default 0x0092) and `dev_rst_i` is low. The accepted `wdata_i` byte is stored at that clock edge.
- R3: `a20_en_o` equals bit 1 of the stored byte. It takes the written bit 1 on the cycle after every accepted write, whatever bit 0 holds.
- R4: An accepted write with `wdata_i[0]`=1 while stored bit 0 is 0 raises `sys_rst_req_o` on the next cycle. The output stays high for exactly `RST_PULSE_CYCLES` cycles (default 4).
- R5: An accepted write with `wdata_i[0]`=1 while stored bit 0 is already 1 raises no request.
- R6: A qualifying 0-to-1 write during an active pulse restarts the count. The output then stays high for `RST_PULSE_CYCLES` cycles after that write.
- R7: A read with `rd_i` high at `PORT_ADDR` puts the stored byte on `rdata_o` on the next cycle. If a write happens in the same cycle, the read returns the value from before that write.
- R8: A cycle with `dev_rst_i` high has three effects:
  - It clears stored bit 0 at that edge and keeps bits 7..1 and `a20_en_o`.
  - It drops any write in the same cycle.
  - It does not shorten a pulse that is already running.
- R9: An access to any address other than `PORT_ADDR` leaves the stored byte, `a20_en_o` and `sys_rst_req_o` unaffected. `rdata_o` is 0 on every cycle that does not follow an addressed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low; clears the whole byte |
| dev_rst_i | input | 1 | Synchronous device reset; clears bit 0 only |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data; valid on the cycle after `rd_i` |
| a20_en_o | output | 1 | Address-line-20 gate enable (stored bit 1) |
| sys_rst_req_o | output | 1 | System reset request pulse |

## Verification
Every result of this block appears exactly one cycle after the strobe that causes it:
- the gate output after an accepted write;
- read data after a read strobe;
- the first high cycle of the reset request after the qualifying write.

The bench drives inputs on the falling edge. It samples all three outputs on the next falling edge, which is half a period after the edge that registers them. On every cycle it compares them against a behavioural model that advances on the rising edge.

Pulse length and restart are checked by counting the high cycles in a window, starting at the first sample after the triggering write.

// File: rtl/sys_ctl_port_pkg.sv
package sys_ctl_port_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned RST_BIT  = 0;
  localparam int unsigned GATE_BIT = 1;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/port_decode.sv
module port_decode #(
  parameter int unsigned    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dev_rst_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic hit;
  assign hit      = (addr_i == PORT_ADDR);
  // device reset wins over a concurrent write
  assign wr_hit_o = wr_i & hit & ~dev_rst_i;
  assign rd_hit_o = rd_i & hit;
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg
  import sys_ctl_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  rd_en_i,
  input  logic  dev_rst_i,
  input  byte_t wdata_i,
  output byte_t q_o,
  output byte_t rdata_o,
  output logic  set_edge_o
);
  byte_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (dev_rst_i) begin
      q[RST_BIT] <= 1'b0;
    end else if (wr_en_i) begin
      q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? q : '0;
  end

  assign set_edge_o = wr_en_i & wdata_i[RST_BIT] & ~q[RST_BIT];
  assign q_o        = q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (trig_i)      cnt <= LOAD;  // restart on a new edge
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign pulse_o = (cnt != '0);
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import sys_ctl_port_pkg::*;
#(
  parameter int unsigned       ADDR_W           = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR        = 'h92,
  parameter int unsigned       RST_PULSE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              a20_en_o,
  output logic              sys_rst_req_o
);
  logic  wr_hit, rd_hit, set_edge;
  byte_t q;

  port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_dec (
    .addr_i, .wr_i, .rd_i, .dev_rst_i,
    .wr_hit_o(wr_hit), .rd_hit_o(rd_hit)
  );

  ctl_reg i_reg (
    .clk_i, .rst_ni,
    .wr_en_i(wr_hit), .rd_en_i(rd_hit), .dev_rst_i,
    .wdata_i, .q_o(q), .rdata_o, .set_edge_o(set_edge)
  );

  rst_pulse_gen #(.CYCLES(RST_PULSE_CYCLES)) i_pulse (
    .clk_i, .rst_ni, .trig_i(set_edge), .pulse_o(sys_rst_req_o)
  );

  assign a20_en_o = q[GATE_BIT];
endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              wdata_gate_i,
  input logic              wdata_rst_i,
  input logic [7:0]        rdata_o,
  input logic              a20_en_o,
  input logic              sys_rst_req_o
);
  logic hit;
  assign hit = (addr_i == PORT_ADDR);

  a_r3_gate_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && !dev_rst_i) |=> (a20_en_o == $past(wdata_gate_i)));

  a_r4_req_needs_set_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(wr_i && hit && !dev_rst_i && wdata_rst_i));

  a_r8_dev_rst_keeps_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> $stable(a20_en_o));

  a_r9_gate_stable_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit) |=> $stable(a20_en_o));

  a_r9_rdata_zero_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && hit) |=> (rdata_o == 8'h00));
endmodule

bind sys_ctl_port sys_ctl_port_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dev_rst_i(dev_rst_i), .addr_i(addr_i),
  .wr_i(wr_i), .rd_i(rd_i), .wdata_gate_i(wdata_i[1]), .wdata_rst_i(wdata_i[0]),
  .rdata_o(rdata_o), .a20_en_o(a20_en_o), .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/test_sys_ctl_port.sv
`timescale 1ns/1ps
module test_sys_ctl_port;
  localparam int N = 4;
  localparam logic [15:0] PA = 16'h0092;

  logic clk = 1'b0, rst_ni = 1'b0, dev_rst = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic a20, req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sys_ctl_port #(.ADDR_W(16), .PORT_ADDR(PA), .RST_PULSE_CYCLES(N)) i_sys_ctl_port (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_i(dev_rst), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .a20_en_o(a20), .sys_rst_req_o(req)
  );

  // behavioural reference
  int m_reg = 0, m_rd = 0, m_left = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = 0; m_rd = 0; m_left = 0;
    end else begin
      bit acc;
      acc  = wr && addr == PA && !dev_rst;
      m_rd = (rd && addr == PA) ? m_reg : 0;
      if (m_left > 0) m_left--;
      if (acc && wdata[0] && !m_reg[0]) m_left = N;
      if (dev_rst) m_reg = m_reg & 'hFE;
      else if (acc) m_reg = wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    chk("R3 a20 vs model", a20, (m_reg >> 1) & 1);
    chk("R4 req vs model", req, m_left > 0);
    chk("R7 rdata vs model", rdata, m_rd);
  end

  logic s_req, s_a20;
  logic [7:0] s_rd;
  task automatic cyc(bit w, bit r, logic [15:0] a, logic [7:0] d, bit dv);
    @(negedge clk);
    s_req = req; s_a20 = a20; s_rd = rdata;
    wr = w; rd = r; addr = a; wdata = d; dev_rst = dv;
  endtask
  task automatic idle(); cyc(0, 0, PA, 8'h00, 0); endtask
  task automatic rd_chk(string tag, int exp);
    cyc(0, 1, PA, 8'h00, 0); idle(); chk(tag, s_rd, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    #12;
    chk("R1 rdata in reset", rdata, 0);
    chk("R1 a20 in reset", a20, 0);
    chk("R1 req in reset", req, 0);
    @(negedge clk); rst_ni = 1'b1;
    rd_chk("R1 byte after reset", 8'h00);

    // R2 R3: gate on via write
    cyc(1, 0, PA, 8'h02, 0); idle();
    chk("R3 a20 set", s_a20, 1);
    chk("R2 no req on gate write", s_req, 0);
    rd_chk("R2 stored 02", 8'h02);

    // R9: other address
    cyc(1, 0, 16'h0093, 8'h5D, 0); idle();
    chk("R9 a20 unchanged", s_a20, 1);
    chk("R9 no req", s_req, 0);
    cyc(0, 1, 16'h0093, 8'h00, 0); idle();
    chk("R9 miss read zero", s_rd, 0);
    rd_chk("R9 byte unchanged", 8'h02);

    // R4: pulse length
    cyc(1, 0, PA, 8'h03, 0);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin idle(); if (s_req) cnt++; end
    chk("R4 pulse length", cnt, N);

    // R5: bit 0 already set
    cyc(1, 0, PA, 8'h03, 0);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin idle(); if (s_req) cnt++; end
    chk("R5 no req when already set", cnt, 0);

    // R8: device reset clears bit 0 only
    cyc(0, 0, PA, 8'h00, 1); idle();
    chk("R8 a20 kept", s_a20, 1);
    rd_chk("R8 bit0 cleared", 8'h02);
    cyc(1, 0, PA, 8'hFD, 1); idle();
    rd_chk("R8 concurrent write dropped", 8'h02);

    // R6: restart during pulse
    cyc(1, 0, PA, 8'h01, 0);
    cyc(1, 0, PA, 8'h00, 0);
    cnt = s_req ? 1 : 0;
    cyc(1, 0, PA, 8'h01, 0);
    if (s_req) cnt++;
    for (int i = 0; i < 10; i++) begin idle(); if (s_req) cnt++; end
    chk("R6 restarted pulse length", cnt, N + 2);
    chk("R3 a20 cleared", s_a20, 0);

    // R7: read with concurrent write returns old value
    cyc(1, 1, PA, 8'h80, 0); idle();
    chk("R7 read-during-write old", s_rd, 8'h01);
    rd_chk("R7 new value", 8'h80);

    // R8: device reset does not shorten running pulse
    cyc(1, 0, PA, 8'h81, 0);
    cyc(0, 0, PA, 8'h00, 1);
    cnt = s_req ? 1 : 0;
    for (int i = 0; i < 10; i++) begin idle(); if (s_req) cnt++; end
    chk("R8 pulse survives dev reset", cnt, N);
    rd_chk("R8 upper bits kept", 8'h80);

    // R1: power-on reset clears all bits
    cyc(1, 0, PA, 8'hFE, 0); idle();
    rst_ni = 1'b0; #1;
    chk("R1 a20 cleared by por", a20, 0);
    @(negedge clk); rst_ni = 1'b1;
    rd_chk("R1 byte cleared by por", 8'h00);

    repeat (3) idle();
    finish_run();
  end
endmodule